// File: doc/BRIEF.md
# Pending Event Filter with Inertial Delay

This block keeps the short list of scheduled output changes for one gate output in an event-driven logic evaluator. Each stored entry is a time stamp and a one-bit value. When a new change is proposed, the filter decides whether to store it, drop it as redundant, or cancel a stored change that the new one has made pointless. The aim is that later evaluation never works on changes that would leave the output where it already is.

A pulse narrower than the programmable inertial delay is swallowed. If the new change would return the output to its previous level too soon after the last stored change, that stored change is cancelled and the new one is not kept. Two storage slots are provided because a gate output rarely holds more than two pending changes. A request that would need a third slot raises an overflow response. A retire strobe removes the earliest entry once simulation time reaches it. A clear input empties the list.

Top module: `evt_filter`

## Requirements
- R1: After reset, and in the cycle after `clear` is high, both slots are empty and `resp_valid` is 0. `clear` takes priority over any request or retire in the same cycle.
- R2: With no entries pending, a request is stored in slot 0 with `resp_accept`=1 only when `req_val` differs from the reference level. Otherwise it is discarded with `resp_accept`=0. The reference level is `cur_val`, or the value of the retired entry when `retire` is high in the same cycle.
- R3: A request whose time is greater than or equal to the time of the last stored entry is discarded when its value equals that entry's value. Otherwise it is appended after it, subject to R4 and R7.
- R4: When an appended change differs from the last entry by less than `inertial_dly` (new time minus last time, unsigned), and its value equals the level before that entry, the last entry is removed and the request is discarded. A difference equal to `inertial_dly` does not trigger this.
- R5: A request earlier (strictly smaller time) than slot 0 is placed in slot 0. If its value equals the old slot 0 value, the old slot 0 entry is dropped and slot 1 is kept. Otherwise the old slot 0 entry moves to slot 1.
- R6: A request between the two entries (slot 0 time <= time < slot 1 time) is discarded if its value equals slot 0's value. Otherwise it replaces slot 1.
- R7: A request that would need a third slot gives `overflow`=1 and `resp_accept`=0 in its response cycle, and the slots keep their contents.
- R8: `retire` removes slot 0 and moves slot 1 into slot 0. A request in the same cycle is judged against the list as it stands after the removal.
- R9: The response (`resp_valid`, `resp_accept`, `overflow`) and the new slot contents appear after the clock edge that samples `req_valid`=1, and `resp_valid` falls after an edge with `req_valid`=0.
- R10: Stored entries always alternate in value and never decrease in time from slot 0 to slot 1, and slot 1 is never occupied while slot 0 is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Empty both slots |
| cur_val | input | 1 | Committed level of the gate output |
| req_valid | input | 1 | Proposed change present |
| req_time | input | 32 | Time of proposed change |
| req_val | input | 1 | Value of proposed change |
| inertial_dly | input | 32 | Minimum pulse width kept |
| retire | input | 1 | Remove the earliest entry |
| p0_valid | output | 1 | Slot 0 occupied |
| p0_time | output | 32 | Slot 0 time |
| p0_val | output | 1 | Slot 0 value |
| p1_valid | output | 1 | Slot 1 occupied |
| p1_time | output | 32 | Slot 1 time |
| p1_val | output | 1 | Slot 1 value |
| resp_valid | output | 1 | Response to last cycle's request |
| resp_accept | output | 1 | Request was stored |
| overflow | output | 1 | Request needed a third slot and was dropped |

## Verification
The alternation and ordering checks assume that `cur_val` is only ever the level the gate really holds. They also assume that retire is pulsed only when the earliest entry is due. The directed scenarios drive `cur_val` as that committed level and step through each insertion case against a small known list. The order of that list therefore follows only from the rules, never from arbitrary slot contents. Time stamps stay far from the 32-bit wrap, so the unsigned difference used by the inertial check is always the true distance.

// File: rtl/evt_filter_pkg.sv
package evt_filter_pkg;
  localparam int TIME_W = 32;

  typedef struct packed {
    logic              valid;
    logic [TIME_W-1:0] tstamp;
    logic              value;
  } evt_t;

  localparam evt_t EVT_NONE = '{valid: 1'b0, tstamp: '0, value: 1'b0};
endpackage

// File: rtl/evt_retire_view.sv
module evt_retire_view
  import evt_filter_pkg::*;
(
  input  evt_t slot0_i,
  input  evt_t slot1_i,
  input  logic retire_i,
  input  logic cur_val_i,
  output evt_t view0_o,
  output evt_t view1_o,
  output logic base_o
);
  always_comb begin
    view0_o = slot0_i;
    view1_o = slot1_i;
    base_o  = cur_val_i;
    if (retire_i && slot0_i.valid) begin
      view0_o = slot1_i;
      view1_o = EVT_NONE;
      base_o  = slot0_i.value;
    end
  end
endmodule

// File: rtl/evt_decide.sv
module evt_decide
  import evt_filter_pkg::*;
(
  input  evt_t              view0_i,
  input  evt_t              view1_i,
  input  logic              base_i,
  input  logic [TIME_W-1:0] req_time_i,
  input  logic              req_val_i,
  input  logic [TIME_W-1:0] inertial_i,
  output evt_t              next0_o,
  output evt_t              next1_o,
  output logic              accept_o,
  output logic              ovf_o
);
  evt_t              incoming;
  evt_t              last;
  logic              before_last;
  logic [TIME_W-1:0] gap;
  logic              after_last;

  always_comb begin
    incoming    = '{valid: 1'b1, tstamp: req_time_i, value: req_val_i};
    last        = view1_i.valid ? view1_i : view0_i;
    before_last = view1_i.valid ? view0_i.value : base_i;
    gap         = req_time_i - last.tstamp;
    after_last  = (req_time_i >= last.tstamp);
  end

  always_comb begin
    next0_o  = view0_i;
    next1_o  = view1_i;
    accept_o = 1'b0;
    ovf_o    = 1'b0;
    if (!view0_i.valid) begin
      if (req_val_i != base_i) begin
        next0_o  = incoming;
        accept_o = 1'b1;
      end
    end else if (after_last) begin
      if (req_val_i != last.value) begin
        if ((gap < inertial_i) && (req_val_i == before_last)) begin
          if (view1_i.valid) next1_o = EVT_NONE;
          else               next0_o = EVT_NONE;
        end else if (view1_i.valid) begin
          ovf_o = 1'b1;
        end else begin
          next1_o  = incoming;
          accept_o = 1'b1;
        end
      end
    end else if (req_time_i < view0_i.tstamp) begin
      if (req_val_i == view0_i.value) begin
        next0_o  = incoming;
        accept_o = 1'b1;
      end else if (view1_i.valid) begin
        ovf_o = 1'b1;
      end else begin
        next0_o  = incoming;
        next1_o  = view0_i;
        accept_o = 1'b1;
      end
    end else begin
      if (req_val_i != view0_i.value) begin
        next1_o  = incoming;
        accept_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_filter.sv
module evt_filter
  import evt_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cur_val,
  input  logic              req_valid,
  input  logic [TIME_W-1:0] req_time,
  input  logic              req_val,
  input  logic [TIME_W-1:0] inertial_dly,
  input  logic              retire,
  output logic              p0_valid,
  output logic [TIME_W-1:0] p0_time,
  output logic              p0_val,
  output logic              p1_valid,
  output logic [TIME_W-1:0] p1_time,
  output logic              p1_val,
  output logic              resp_valid,
  output logic              resp_accept,
  output logic              overflow
);
  evt_t slot0_q, slot1_q, slot0_d, slot1_d;
  evt_t view0, view1, dec0, dec1;
  logic base, dec_accept, dec_ovf;
  logic rv_d, ra_d, ro_d;
  logic slot_en;

  evt_retire_view u_view (
    .slot0_i(slot0_q), .slot1_i(slot1_q), .retire_i(retire),
    .cur_val_i(cur_val), .view0_o(view0), .view1_o(view1), .base_o(base)
  );

  evt_decide u_decide (
    .view0_i(view0), .view1_i(view1), .base_i(base),
    .req_time_i(req_time), .req_val_i(req_val), .inertial_i(inertial_dly),
    .next0_o(dec0), .next1_o(dec1), .accept_o(dec_accept), .ovf_o(dec_ovf)
  );

  always_comb begin
    slot_en = clear | req_valid | retire;
    slot0_d = req_valid ? dec0 : view0;
    slot1_d = req_valid ? dec1 : view1;
    rv_d    = req_valid;
    ra_d    = req_valid & dec_accept;
    ro_d    = req_valid & dec_ovf;
    if (clear) begin
      slot0_d = EVT_NONE;
      slot1_d = EVT_NONE;
      rv_d    = 1'b0;
      ra_d    = 1'b0;
      ro_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0_q <= EVT_NONE;
      slot1_q <= EVT_NONE;
    end else if (slot_en) begin
      slot0_q <= slot0_d;
      slot1_q <= slot1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_accept <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      resp_valid  <= rv_d;
      resp_accept <= ra_d;
      overflow    <= ro_d;
    end
  end

  assign p0_valid = slot0_q.valid;
  assign p0_time  = slot0_q.tstamp;
  assign p0_val   = slot0_q.value;
  assign p1_valid = slot1_q.valid;
  assign p1_time  = slot1_q.tstamp;
  assign p1_val   = slot1_q.value;

  assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!p0_valid && !p1_valid && !resp_valid));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (resp_valid && !resp_accept));
  assert_resp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid) |=> !resp_valid);
  assert_slot_chain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    p1_valid |-> p0_valid);
  assert_alternate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && p1_valid) |-> (p0_val != p1_val));
  assert_time_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && p1_valid) |-> (p0_time <= p1_time));
endmodule

// File: tb/test_evt_filter.sv
module test_evt_filter;
  logic        clk = 1'b0;
  logic        rst_n, clear, cur_val, req_valid, req_val, retire;
  logic [31:0] req_time, inertial_dly;
  logic        p0_valid, p0_val, p1_valid, p1_val;
  logic [31:0] p0_time, p1_time;
  logic        resp_valid, resp_accept, overflow;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  evt_filter i_evt_filter (
    .clk(clk), .rst_n(rst_n), .clear(clear), .cur_val(cur_val),
    .req_valid(req_valid), .req_time(req_time), .req_val(req_val),
    .inertial_dly(inertial_dly), .retire(retire),
    .p0_valid(p0_valid), .p0_time(p0_time), .p0_val(p0_val),
    .p1_valid(p1_valid), .p1_time(p1_time), .p1_val(p1_val),
    .resp_valid(resp_valid), .resp_accept(resp_accept), .overflow(overflow)
  );

  task automatic check_slots(input string tag,
      input logic v0, input logic [31:0] t0, input logic x0,
      input logic v1, input logic [31:0] t1, input logic x1);
    logic [33:0] a0, a1, e0, e1;
    a0 = {p0_valid, p0_valid ? p0_time : 32'd0, p0_valid & p0_val};
    a1 = {p1_valid, p1_valid ? p1_time : 32'd0, p1_valid & p1_val};
    e0 = {v0, v0 ? t0 : 32'd0, v0 & x0};
    e1 = {v1, v1 ? t1 : 32'd0, v1 & x1};
    checks++;
    if (a0 !== e0 || a1 !== e1) begin
      errors++;
      $display("FAIL %s slots actual %h/%h expected %h/%h", tag, a0, a1, e0, e1);
    end
  endtask

  task automatic check_resp(input string tag, input logic rv, input logic ra, input logic ro);
    checks++;
    if ({resp_valid, resp_accept, overflow} !== {rv, ra, ro}) begin
      errors++;
      $display("FAIL %s resp actual %b%b%b expected %b%b%b", tag,
               resp_valid, resp_accept, overflow, rv, ra, ro);
    end
  endtask

  task automatic step(input logic rq, input logic [31:0] t, input logic v,
                      input logic ret, input logic clr);
    @(negedge clk);
    req_valid = rq; req_time = t; req_val = v; retire = ret; clear = clr;
    @(posedge clk); #1;
    req_valid = 1'b0; retire = 1'b0; clear = 1'b0;
  endtask

  task automatic t_reset;
    check_slots("R1 reset", 0, 0, 0, 0, 0, 0);
    check_resp("R1 reset", 0, 0, 0);
  endtask

  task automatic t_empty;
    cur_val = 1'b0;
    step(1, 10, 0, 0, 0);
    check_resp("R2 same as committed", 1, 0, 0);
    check_slots("R2 same as committed", 0, 0, 0, 0, 0, 0);
    step(1, 10, 1, 0, 0);
    check_resp("R2 differs R9", 1, 1, 0);
    check_slots("R2 differs", 1, 10, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    check_resp("R9 idle", 0, 0, 0);
  endtask

  task automatic t_append_overflow;
    step(1, 20, 1, 0, 0);
    check_resp("R3 same as last", 1, 0, 0);
    check_slots("R3 same as last", 1, 10, 1, 0, 0, 0);
    step(1, 20, 0, 0, 0);
    check_resp("R3 append", 1, 1, 0);
    check_slots("R3 append", 1, 10, 1, 1, 20, 0);
    step(1, 30, 1, 0, 0);
    check_resp("R7 third slot", 1, 0, 1);
    check_slots("R7 unchanged", 1, 10, 1, 1, 20, 0);
  endtask

  task automatic t_retire;
    cur_val = 1'b1;
    step(0, 0, 0, 1, 0);
    check_slots("R8 pop", 1, 20, 0, 0, 0, 0);
    step(1, 40, 1, 1, 0);
    check_resp("R8 retire first", 1, 1, 0);
    check_slots("R8 retire first", 1, 40, 1, 0, 0, 0);
    step(1, 50, 0, 0, 1);
    check_slots("R1 clear", 0, 0, 0, 0, 0, 0);
    check_resp("R1 clear", 0, 0, 0);
  endtask

  task automatic t_inertial;
    cur_val = 1'b0; inertial_dly = 5;
    step(1, 100, 1, 0, 0);
    step(1, 103, 0, 0, 0);
    check_resp("R4 short pulse", 1, 0, 0);
    check_slots("R4 short pulse", 0, 0, 0, 0, 0, 0);
    step(1, 100, 1, 0, 0);
    step(1, 105, 0, 0, 0);
    check_resp("R4 equal width kept", 1, 1, 0);
    check_slots("R4 equal width kept", 1, 100, 1, 1, 105, 0);
    inertial_dly = 0;
  endtask

  task automatic t_front_between;
    step(1, 90, 1, 0, 0);
    check_resp("R5 front same", 1, 1, 0);
    check_slots("R5 front same", 1, 90, 1, 1, 105, 0);
    step(0, 0, 0, 0, 1);
    step(1, 100, 1, 0, 0);
    step(1, 90, 0, 0, 0);
    check_slots("R5 front shift", 1, 90, 0, 1, 100, 1);
    step(1, 80, 1, 0, 0);
    check_resp("R7 front full", 1, 0, 1);
    check_slots("R7 front full", 1, 90, 0, 1, 100, 1);
    step(1, 95, 0, 0, 0);
    check_resp("R6 between same", 1, 0, 0);
    check_slots("R6 between same", 1, 90, 0, 1, 100, 1);
    step(1, 95, 1, 0, 0);
    check_resp("R6 between differs", 1, 1, 0);
    check_slots("R6 R10 between differs", 1, 90, 0, 1, 95, 1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clear = 1'b0; cur_val = 1'b0; req_valid = 1'b0;
    req_val = 1'b0; retire = 1'b0; req_time = '0; inertial_dly = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_empty();
    t_append_overflow();
    t_retire();
    t_inertial();
    t_front_between();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule